// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block takes the 48-bit destination address of a received frame and decides whether the frame is kept. Group (multicast) addresses are hashed with a CRC-32. The CRC is computed one bit per clock over the six address octets. Six bits of the result pick one bit out of a 64-bit table, which software holds as two 32-bit words. That bit decides whether the frame is kept.

The remaining address classes bypass the table. Broadcast frames are kept unless a broadcast-reject control is set. Individual (unicast) addresses are kept only when they equal the programmed station address. A promiscuous control keeps every frame.

A caller presents an address with a one-cycle valid strobe while the block is idle. Exactly 49 clocks after the strobe edge, the block raises a one-cycle done pulse. The accept verdict and the hash slot that was looked up are presented with it. Strobes that arrive while a computation is running are dropped. The table, station address and control inputs are sampled when the verdict is formed, one cycle before done.

Top module: `mhash_filter`

## Requirements
- R1: The CRC register is seeded with all ones. Each step shifts it left by one. The step XORs in polynomial 0x04C11DB7 after the shift whenever the old bit 31 XOR the incoming address bit is 1.
- R2: Octets are fed first octet first, where the first octet is dest_addr[47:40]. Within an octet, bits are fed least significant first, one bit per step, for 48 steps.
- R3: The table index is CRC bits [5:1] bit-reversed: CRC bit 1 becomes index bit 4 and CRC bit 5 becomes index bit 0. It is reported in hash_slot[4:0].
- R4: CRC bit 0 picks the table half, 1 for tbl_hi and 0 for tbl_lo. It is reported in hash_slot[5].
- R5: A group address (dest_addr[40] = 1) that is not broadcast, with promiscuous mode off, is accepted exactly when the selected table bit is 1.
- R6: With promisc_en = 1, every address is accepted, broadcast included, whatever the table and bcast_rej hold.
- R7: The all-ones address, with promiscuous mode off, is rejected when bcast_rej = 1 and accepted otherwise.
- R8: With both table words all ones and promiscuous mode off, every non-broadcast group address is accepted.
- R9: An individual address (dest_addr[40] = 0), with promiscuous mode off, is accepted exactly when it equals station_addr.
- R10: A strobe taken while busy is low makes busy high from the next cycle. busy then stays high for 49 cycles. done is high for exactly one cycle, 49 cycles after the strobe edge, and busy is low in that cycle.
- R11: A strobe that arrives while busy is high has no effect: the result and its timing belong to the address already being processed.
- R12: While and after reset, busy, done, accept and hash_slot are all 0. accept is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | Address strobe, taken only while idle |
| dest_addr | input | 48 | Destination address, first octet in [47:40] |
| promisc_en | input | 1 | Keep every frame |
| bcast_rej | input | 1 | Reject the all-ones address |
| station_addr | input | 48 | Own individual address |
| tbl_hi | input | 32 | Hash table half picked when CRC bit 0 is 1 |
| tbl_lo | input | 32 | Hash table half picked when CRC bit 0 is 0 |
| busy | output | 1 | A hash computation is in progress |
| done | output | 1 | One-cycle result pulse |
| accept | output | 1 | Verdict, valid with done |
| hash_slot | output | 6 | {half, index} of the last lookup |

## Verification
The bench aims at the hash arithmetic first. A wrong octet or bit order, an unreversed index, or a swapped half select makes hash_slot differ from a model computed from the address alone. One-hot tables then turn such a slip into a wrong accept. All-zero, all-ones and broadcast addresses are run under each control setting. A design that lets the reject control override promiscuous mode, or that sends broadcast through the table, gives the wrong verdict there. A stray strobe in mid-computation and at the last busy cycle would restart or corrupt a design that does not hold it off; such a design shows up as a late done or a slot that belongs to the stray address.

// File: rtl/mhash_pkg.sv
package mhash_pkg;

    localparam int MAC_W    = 48;
    localparam int OCT_W    = 8;
    localparam int OCTETS   = MAC_W / OCT_W;
    localparam int CRC_W    = 32;
    localparam int HALF_W   = 32;
    localparam int IDX_W    = $clog2(HALF_W);
    localparam int SLOT_W   = IDX_W + 1;
    localparam int STEP_W   = $clog2(MAC_W + 1);
    localparam int GROUP_BIT = MAC_W - OCT_W;
    localparam logic [CRC_W-1:0] CRC_SEED = '1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_RESOLVE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CLS_INDIV = 2'd0,
        CLS_GROUP = 2'd1,
        CLS_BCAST = 2'd2
    } addr_class_e;

    typedef struct packed {
        logic             half;
        logic [IDX_W-1:0] idx;
    } slot_t;

    typedef struct packed {
        logic  accept;
        slot_t slot;
    } verdict_t;

    function automatic logic [CRC_W-1:0] crc_advance(
        input logic [CRC_W-1:0] cur,
        input logic             din,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] nxt;
        nxt = {cur[CRC_W-2:0], 1'b0};
        if (cur[CRC_W-1] ^ din)
            nxt = nxt ^ poly;
        return nxt;
    endfunction

    // Arrange the address so that bit 0 is the first bit put on the wire.
    function automatic logic [MAC_W-1:0] wire_order(input logic [MAC_W-1:0] a);
        logic [MAC_W-1:0] s;
        for (int o = 0; o < OCTETS; o++)
            for (int b = 0; b < OCT_W; b++)
                s[o*OCT_W + b] = a[MAC_W - OCT_W - o*OCT_W + b];
        return s;
    endfunction

    function automatic slot_t slot_of(input logic [CRC_W-1:0] crc);
        slot_t r;
        r.half = crc[0];
        for (int k = 0; k < IDX_W; k++)
            r.idx[IDX_W-1-k] = crc[1+k];
        return r;
    endfunction

endpackage

// File: rtl/mhash_seq.sv
module mhash_seq
    import mhash_pkg::*;
#(
    parameter int STEPS = MAC_W
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic load,
    output logic shift,
    output logic resolve,
    output logic busy
);
    localparam int CW = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    seq_state_e      state_q;
    logic [CW-1:0]   cnt_q;

    assign load    = strobe && (state_q == ST_IDLE);
    assign shift   = (state_q == ST_SHIFT);
    assign resolve = (state_q == ST_RESOLVE);
    assign busy    = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (strobe)
                        state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST)
                        state_q <= ST_RESOLVE;
                end
                ST_RESOLVE: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mhash_crc.sv
module mhash_crc
    import mhash_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [MAC_W-1:0] addr,
    output logic [CRC_W-1:0] crc
);
    logic [MAC_W-1:0] stream_q;
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stream_q <= '0;
            crc_q    <= CRC_SEED;
        end else if (load) begin
            stream_q <= wire_order(addr);
            crc_q    <= CRC_SEED;
        end else if (shift) begin
            stream_q <= {1'b0, stream_q[MAC_W-1:1]};
            crc_q    <= crc_advance(crc_q, stream_q[0], POLY);
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/mhash_decide.sv
module mhash_decide
    import mhash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              resolve,
    input  logic [CRC_W-1:0]  crc,
    input  logic [MAC_W-1:0]  addr,
    input  logic [MAC_W-1:0]  station,
    input  logic              promisc,
    input  logic              bc_reject,
    input  logic [HALF_W-1:0] tbl_hi,
    input  logic [HALF_W-1:0] tbl_lo,
    output logic              done,
    output logic              accept,
    output slot_t             slot
);
    addr_class_e      cls;
    verdict_t         v;
    logic [HALF_W-1:0] half_word;

    always_comb begin
        if (&addr)
            cls = CLS_BCAST;
        else if (addr[GROUP_BIT])
            cls = CLS_GROUP;
        else
            cls = CLS_INDIV;
    end

    always_comb begin
        v.slot    = slot_of(crc);
        half_word = v.slot.half ? tbl_hi : tbl_lo;
        if (promisc)
            v.accept = 1'b1;
        else begin
            case (cls)
                CLS_BCAST: v.accept = !bc_reject;
                CLS_GROUP: v.accept = half_word[v.slot.idx];
                default:   v.accept = (addr == station);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            accept <= 1'b0;
            slot   <= '0;
        end else begin
            done   <= resolve;
            accept <= resolve && v.accept;
            if (resolve)
                slot <= v.slot;
        end
    end

endmodule

// File: rtl/mhash_filter.sv
module mhash_filter
    import mhash_pkg::*;
#(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         addr_vld,
    input  logic [47:0]  dest_addr,
    input  logic         promisc_en,
    input  logic         bcast_rej,
    input  logic [47:0]  station_addr,
    input  logic [31:0]  tbl_hi,
    input  logic [31:0]  tbl_lo,
    output logic         busy,
    output logic         done,
    output logic         accept,
    output logic [5:0]   hash_slot
);
    logic             load, shift, resolve;
    logic [MAC_W-1:0] addr_q;
    logic [CRC_W-1:0] crc;
    slot_t            slot;

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= dest_addr;
    end

    mhash_seq #(.STEPS(MAC_W)) u_seq (
        .clk(clk), .rst(rst), .strobe(addr_vld),
        .load(load), .shift(shift), .resolve(resolve), .busy(busy)
    );

    mhash_crc #(.POLY(POLY)) u_crc (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .addr(dest_addr), .crc(crc)
    );

    mhash_decide u_decide (
        .clk(clk), .rst(rst), .resolve(resolve), .crc(crc),
        .addr(addr_q), .station(station_addr),
        .promisc(promisc_en), .bc_reject(bcast_rej),
        .tbl_hi(tbl_hi), .tbl_lo(tbl_lo),
        .done(done), .accept(accept), .slot(slot)
    );

    assign hash_slot = slot;

endmodule

// File: rtl/mhash_filter_chk.sv
module mhash_filter_chk (
    input logic clk,
    input logic rst,
    input logic addr_vld,
    input logic promisc_en,
    input logic busy,
    input logic done,
    input logic accept
);
    localparam int RUN_LEN = 49;
    localparam int RW = $clog2(RUN_LEN + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (busy)
            run_q <= (run_q == RW'(RUN_LEN + 1)) ? run_q : run_q + 1'b1;
        else
            run_q <= '0;
    end

    // R10
    start_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_vld && !busy) |=> busy);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R11
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_q == RW'(RUN_LEN)));

    // R12
    accept_gated_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> done);

    // R6
    promisc_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(promisc_en)) |-> accept);

endmodule

bind mhash_filter mhash_filter_chk u_chk (
    .clk(clk), .rst(rst), .addr_vld(addr_vld), .promisc_en(promisc_en),
    .busy(busy), .done(done), .accept(accept)
);

// File: tb/mhash_filter_test.sv
module mhash_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_vld = 1'b0;
    logic [47:0] dest_addr = '0;
    logic        promisc_en = 1'b0;
    logic        bcast_rej = 1'b0;
    logic [47:0] station_addr = '0;
    logic [31:0] tbl_hi = '0;
    logic [31:0] tbl_lo = '0;
    logic        busy, done, accept;
    logic [5:0]  hash_slot;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mhash_filter uut (
        .clk(clk), .rst(rst), .addr_vld(addr_vld), .dest_addr(dest_addr),
        .promisc_en(promisc_en), .bcast_rej(bcast_rej),
        .station_addr(station_addr), .tbl_hi(tbl_hi), .tbl_lo(tbl_lo),
        .busy(busy), .done(done), .accept(accept), .hash_slot(hash_slot)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1 R2: CRC model written from the requirement text.
    function automatic logic [31:0] model_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int o = 0; o < 6; o++) begin
            logic [7:0] oct = a[47 - 8*o -: 8];
            for (int b = 0; b < 8; b++) begin
                logic fb = c[31] ^ oct[b];
                c = c << 1;
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return c;
    endfunction

    // R3 R4
    function automatic logic [5:0] model_slot(input logic [47:0] a);
        logic [31:0] c = model_crc(a);
        return {c[0], c[1], c[2], c[3], c[4], c[5]};
    endfunction

    function automatic logic model_accept(input logic [47:0] a);
        logic [5:0] s = model_slot(a);
        if (promisc_en) return 1'b1;
        if (a == 48'hFFFFFFFFFFFF) return !bcast_rej;
        if (a[40]) return s[5] ? tbl_hi[s[4:0]] : tbl_lo[s[4:0]];
        return a == station_addr;
    endfunction

    logic       r_acc;
    logic [5:0] r_slot;

    // Runs one address; stray_at in 1..48 drives a second strobe in that cycle.
    task automatic run_one(input logic [47:0] a, input int stray_at,
                           input logic [47:0] stray);
        bit early = 0;
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        addr_vld  = 1'b1;
        dest_addr = a;
        @(posedge clk);
        @(negedge clk);
        addr_vld = 1'b0;
        chk(busy == 1'b1, "R10 busy after strobe", busy, 1);
        for (int c = 1; c <= 48; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) early = 1;
            if (c == stray_at) begin
                addr_vld  = 1'b1;
                dest_addr = stray;
            end else begin
                addr_vld = 1'b0;
            end
        end
        chk(!early, "R10 no early done", early, 0);
        @(posedge clk);
        @(negedge clk);
        addr_vld = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, "R10 done at 49", {done, busy}, 2'b10);
        r_acc  = accept;
        r_slot = hash_slot;
    endtask

    task automatic run_cmp(input logic [47:0] a, input string req);
        logic exp_a = model_accept(a);
        logic [5:0] exp_s = model_slot(a);
        run_one(a, 0, '0);
        chk(r_slot == exp_s, "R3 R4 slot", r_slot, exp_s);
        chk(r_acc == exp_a, req, r_acc, exp_a);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [47:0] a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12
        chk({busy, done, accept, hash_slot} == 0, "R12 in reset",
            {busy, done, accept, hash_slot}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, accept, hash_slot} == 0, "R12 after reset",
            {busy, done, accept, hash_slot}, 0);

        // R5 R1 R2 R3 R4: random group addresses, random tables
        station_addr = 48'h0012_3456_789A;
        for (int i = 0; i < 48; i++) begin
            tbl_hi = $urandom;
            tbl_lo = $urandom;
            a = {$urandom, $urandom};
            a[40] = 1'b1;
            if (a == 48'hFFFFFFFFFFFF) a[0] = 1'b0;
            run_cmp(a, "R5 group via table");
        end

        // R5: one-hot table sweep, hit and neighbour miss
        for (int i = 0; i < 12; i++) begin
            logic [5:0] s;
            a = {$urandom, $urandom};
            a[40] = 1'b1;
            a[1]  = 1'b0;
            s = model_slot(a);
            tbl_hi = '0; tbl_lo = '0;
            if (s[5]) tbl_hi[s[4:0]] = 1'b1; else tbl_lo[s[4:0]] = 1'b1;
            run_cmp(a, "R5 one-hot hit");
            chk(r_acc == 1'b1, "R5 one-hot accepted", r_acc, 1);
            tbl_hi = '0; tbl_lo = '0;
            if (s[5]) tbl_lo[s[4:0]] = 1'b1; else tbl_hi[s[4:0]] = 1'b1;
            run_cmp(a, "R4 other half miss");
            chk(r_acc == 1'b0, "R4 other half rejected", r_acc, 0);
        end

        // R8: all-ones tables
        tbl_hi = '1; tbl_lo = '1;
        for (int i = 0; i < 10; i++) begin
            a = {$urandom, $urandom};
            a[40] = 1'b1; a[2] = 1'b0;
            run_cmp(a, "R8 all-multicast");
            chk(r_acc == 1'b1, "R8 accepted", r_acc, 1);
        end

        // R9: unicast match / mismatch, all-zero address
        tbl_hi = '1; tbl_lo = '1;
        for (int i = 0; i < 6; i++) begin
            a = {$urandom, $urandom};
            a[40] = 1'b0;
            station_addr = a;
            run_cmp(a, "R9 unicast match");
            station_addr = a ^ 48'h1;
            run_cmp(a, "R9 unicast mismatch");
        end
        station_addr = 48'h0000_0000_0001;
        run_cmp(48'h0, "R9 zero address mismatch");
        station_addr = 48'h0;
        run_cmp(48'h0, "R9 zero address match");

        // R7: broadcast
        tbl_hi = '0; tbl_lo = '0;
        bcast_rej = 1'b0;
        run_cmp(48'hFFFFFFFFFFFF, "R7 broadcast kept");
        bcast_rej = 1'b1;
        run_cmp(48'hFFFFFFFFFFFF, "R7 broadcast rejected");

        // R6: promiscuous overrides everything
        promisc_en = 1'b1;
        run_cmp(48'hFFFFFFFFFFFF, "R6 promisc broadcast");
        station_addr = 48'h0000_0000_0005;
        run_cmp(48'h0000_0000_0006, "R6 promisc unicast");
        run_cmp(48'h0100_5E00_0001, "R6 promisc group");
        promisc_en = 1'b0;
        bcast_rej  = 1'b0;

        // R11: stray strobes while busy
        for (int i = 0; i < 6; i++) begin
            logic [5:0] exp_s;
            a = {$urandom, $urandom};
            a[40] = 1'b1;
            exp_s = model_slot(a);
            tbl_hi = '0; tbl_lo = '0;
            if (exp_s[5]) tbl_hi[exp_s[4:0]] = 1'b1; else tbl_lo[exp_s[4:0]] = 1'b1;
            run_one(a, (i == 5) ? 48 : 1 + 9*i, ~a);
            chk(r_slot == exp_s, "R11 stray ignored slot", r_slot, exp_s);
            chk(r_acc == 1'b1, "R11 stray ignored accept", r_acc, 1);
        end
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R11 no restart from stray", {busy, done}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule